// File: doc/BRIEF.md
# Single-Slot Queue with Selectable Same-Cycle Ordering

This block holds at most one data word between a producer and a consumer. A producer offers a word with a push strobe and a consumer takes the word at the head with a pop strobe. Each side watches a ready flag: space available for the producer, data available for the consumer. A strobe raised while its ready flag is low is dropped inside the block and has no effect.

A build-time mode sets the order of a push and a pop that arrive in the same cycle. In drain-first mode the pop is ordered first. A full slot can therefore accept a new word in the same cycle that its old word leaves, which keeps a chain of stages moving every cycle. In forward-first mode the push is ordered first. An empty slot can then hand the arriving word straight to the consumer in that cycle, without holding it for a clock. In both modes the occupancy flag is updated by a fixed priority: the operation ordered later wins, so the flag never gets two conflicting writes.

Top module: `one_slot_queue`

## Requirements
- R1: After synchronous reset the slot is empty. The space-ready flag is 1, and in drain-first mode the data-ready flag is 0.
- R2: Drain-first mode: space-ready is 1 when the slot is empty, or when a pop is presented in the same cycle while data-ready is 1. Otherwise it is 0, and a push made while it is 0 is dropped.
- R3: Drain-first mode: data-ready and the head word depend only on the stored state. A word pushed into an empty slot becomes visible only in the following cycle.
- R4: Drain-first mode: a push and a pop in the same cycle on a full slot leave it full. The head word in the next cycle is the newly pushed word.
- R5: Drain-first mode: a pop presented while data-ready is 0 is dropped, and the slot stays as it was.
- R6: Forward-first mode: data-ready is 1 when the slot is full, or when a push is presented in the same cycle. When the slot is empty and a push is presented, the head output carries the incoming word in that cycle.
- R7: Forward-first mode: space-ready depends only on the stored state. On a full slot a push is dropped, even if a pop is presented in the same cycle, and the stored word is kept.
- R8: Forward-first mode: a push and a pop in the same cycle on an empty slot pass the word through and leave the slot empty at the next edge.
- R9: Words leave in the order they were accepted, with all DATA_W bits intact, and every accepted word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Producer offers a word this cycle |
| push_data_i | input | DATA_W | Word offered by the producer |
| pop_i | input | 1 | Consumer takes the head word this cycle |
| head_o | output | DATA_W | Head word seen by the consumer |
| space_rdy_o | output | 1 | A push made this cycle will be accepted |
| data_rdy_o | output | 1 | A pop made this cycle will be accepted |

## Verification
The bench builds two copies of the block with DATA_W set to 8. One copy runs in drain-first mode and the other in forward-first mode, and both are driven with the same kind of stimulus. This covers both orderings of a same-cycle push and pop, on an empty slot and on a full one. It also covers strobes dropped in each mode, and the combinational forward path, which only forward-first mode has. A mixed stream of pushes and pops then runs through both copies, and a queue model checks the order and value of every word that leaves.

// File: rtl/osq_pkg.sv
package osq_pkg;
  typedef enum logic {
    OSQ_DRAIN_FIRST   = 1'b0,
    OSQ_FORWARD_FIRST = 1'b1
  } osq_mode_e;
endpackage

// File: rtl/osq_store.sv
module osq_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (wr_en) word_q <= wr_data;
  end

  assign rd_data = word_q;
endmodule

// File: rtl/osq_flag.sv
module osq_flag
  import osq_pkg::*;
#(
  parameter osq_mode_e MODE = OSQ_DRAIN_FIRST
) (
  input  logic clk,
  input  logic rst,
  input  logic push_fire,
  input  logic pop_fire,
  output logic full_q
);
  logic full_d;

  generate
    if (MODE == OSQ_DRAIN_FIRST) begin : g_drain
      // pop ordered first, push wins the flag
      always_comb begin
        full_d = full_q;
        if (pop_fire)  full_d = 1'b0;
        if (push_fire) full_d = 1'b1;
      end
    end else begin : g_forward
      // push ordered first, pop wins the flag
      always_comb begin
        full_d = full_q;
        if (push_fire) full_d = 1'b1;
        if (pop_fire)  full_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else     full_q <= full_d;
  end
endmodule

// File: rtl/osq_gate.sv
module osq_gate
  import osq_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter osq_mode_e MODE   = OSQ_DRAIN_FIRST
) (
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              full_q,
  input  logic [DATA_W-1:0] stored,
  output logic              push_fire,
  output logic              pop_fire,
  output logic              space_rdy,
  output logic              data_rdy,
  output logic [DATA_W-1:0] head
);
  generate
    if (MODE == OSQ_DRAIN_FIRST) begin : g_drain
      assign data_rdy  = full_q;
      assign pop_fire  = pop_req & full_q;
      assign space_rdy = ~full_q | pop_fire;
      assign push_fire = push_req & space_rdy;
      assign head      = stored;
    end else begin : g_forward
      assign space_rdy = ~full_q;
      assign push_fire = push_req & ~full_q;
      assign data_rdy  = full_q | push_fire;
      assign pop_fire  = pop_req & data_rdy;
      assign head      = full_q ? stored : push_data;
    end
  endgenerate
endmodule

// File: rtl/one_slot_queue.sv
module one_slot_queue
  import osq_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter osq_mode_e MODE   = OSQ_DRAIN_FIRST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              space_rdy_o,
  output logic              data_rdy_o
);
  logic              full_q;
  logic              push_fire;
  logic              pop_fire;
  logic [DATA_W-1:0] stored;

  osq_gate #(.DATA_W(DATA_W), .MODE(MODE)) u_gate (
    .push_req  (push_i),
    .pop_req   (pop_i),
    .push_data (push_data_i),
    .full_q    (full_q),
    .stored    (stored),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .space_rdy (space_rdy_o),
    .data_rdy  (data_rdy_o),
    .head      (head_o)
  );

  osq_flag #(.MODE(MODE)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .full_q    (full_q)
  );

  osq_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (push_fire),
    .wr_data (push_data_i),
    .rd_data (stored)
  );
endmodule

// File: rtl/one_slot_queue_chk.sv
module one_slot_queue_chk
  import osq_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter osq_mode_e MODE   = OSQ_DRAIN_FIRST
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] head_o,
  input logic              space_rdy_o,
  input logic              data_rdy_o
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> space_rdy_o);

  generate
    if (MODE == OSQ_DRAIN_FIRST) begin : g_drain
      assert_space_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !data_rdy_o |-> space_rdy_o);
      assert_space_on_pop_R2: assert property (@(posedge clk) disable iff (rst)
        (pop_i && data_rdy_o) |-> space_rdy_o);
      assert_push_seen_next_R3: assert property (@(posedge clk) disable iff (rst)
        (push_i && !data_rdy_o) |=> data_rdy_o);
      assert_swap_keeps_full_R4: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && data_rdy_o) |=> (data_rdy_o && head_o == $past(push_data_i)));
      assert_empty_pop_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !data_rdy_o) |=> !data_rdy_o);
    end else begin : g_forward
      assert_forward_head_R6: assert property (@(posedge clk) disable iff (rst)
        (push_i && space_rdy_o) |-> (data_rdy_o && head_o == push_data_i));
      assert_full_push_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !space_rdy_o) |=> $stable(head_o));
      assert_passthrough_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && space_rdy_o) |=> space_rdy_o);
    end
  endgenerate
endmodule

bind one_slot_queue one_slot_queue_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .push_data_i (push_data_i),
  .pop_i       (pop_i),
  .head_o      (head_o),
  .space_rdy_o (space_rdy_o),
  .data_rdy_o  (data_rdy_o)
);

// File: tb/sim_one_slot_queue.sv
module sim_one_slot_queue;
  import osq_pkg::*;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         push0 = 0, pop0 = 0, push1 = 0, pop1 = 0;
  logic [W-1:0] pd0 = '0, pd1 = '0;
  logic [W-1:0] head0, head1;
  logic         sr0, dr0, sr1, dr1;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] sb0[$];
  logic [W-1:0] sb1[$];

  one_slot_queue #(.DATA_W(W), .MODE(OSQ_DRAIN_FIRST)) u0 (
    .clk(clk), .rst(rst), .push_i(push0), .push_data_i(pd0), .pop_i(pop0),
    .head_o(head0), .space_rdy_o(sr0), .data_rdy_o(dr0));

  one_slot_queue #(.DATA_W(W), .MODE(OSQ_FORWARD_FIRST)) u1 (
    .clk(clk), .rst(rst), .push_i(push1), .push_data_i(pd1), .pop_i(pop1),
    .head_o(head1), .space_rdy_o(sr1), .data_rdy_o(dr1));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver and monitor for one cycle on copy m (0 drain-first, 1 forward-first).
  task automatic step(input int m, input bit push, input logic [W-1:0] d,
                      input bit pop, input string tag);
    bit exp_sr, exp_dr, push_ok, pop_ok;
    logic [W-1:0] exp_head;
    int n;
    @(negedge clk);
    if (m == 0) begin push0 = push; pd0 = d; pop0 = pop; end
    else        begin push1 = push; pd1 = d; pop1 = pop; end
    #1;
    n = (m == 0) ? sb0.size() : sb1.size();
    if (m == 0) begin
      exp_dr  = (n != 0);
      pop_ok  = pop && exp_dr;
      exp_sr  = (n == 0) || pop_ok;
      push_ok = push && exp_sr;
      exp_head = (n != 0) ? sb0[0] : '0;
      chk(sr0 == exp_sr, tag, "space_rdy", sr0, exp_sr);
      chk(dr0 == exp_dr, tag, "data_rdy", dr0, exp_dr);
      if (exp_dr) chk(head0 == exp_head, tag, "head", head0, exp_head);
      if (pop_ok) void'(sb0.pop_front());
      if (push_ok) sb0.push_back(d);
    end else begin
      exp_sr  = (n == 0);
      push_ok = push && exp_sr;
      exp_dr  = (n != 0) || push_ok;
      pop_ok  = pop && exp_dr;
      exp_head = (n != 0) ? sb1[0] : d;
      chk(sr1 == exp_sr, tag, "space_rdy", sr1, exp_sr);
      chk(dr1 == exp_dr, tag, "data_rdy", dr1, exp_dr);
      if (exp_dr) chk(head1 == exp_head, tag, "head", head1, exp_head);
      if (push_ok) sb1.push_back(d);
      if (pop_ok) void'(sb1.pop_front());
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state of both copies
    chk(sr0 == 1'b1, "R1", "drain space_rdy", sr0, 1);
    chk(dr0 == 1'b0, "R1", "drain data_rdy", dr0, 0);
    chk(sr1 == 1'b1, "R1", "forward space_rdy", sr1, 1);
    chk(dr1 == 1'b0, "R1", "forward data_rdy", dr1, 0);

    // drain-first copy
    step(0, 1, 8'h11, 0, "R3");   // push into empty, not visible yet
    step(0, 1, 8'h22, 0, "R2");   // full, no pop: push dropped
    step(0, 1, 8'h33, 1, "R4");   // swap on full, head is 0x11
    step(0, 0, 8'h00, 1, "R4");   // head now 0x33
    step(0, 0, 8'h00, 1, "R5");   // pop on empty dropped
    step(0, 1, 8'h44, 1, "R5");   // pop dropped, push accepted
    step(0, 0, 8'h00, 1, "R9");   // yields 0x44
    step(0, 0, 8'h00, 0, "R5");   // empty again

    // forward-first copy
    step(1, 1, 8'h55, 1, "R6");   // empty: word passes through this cycle
    step(1, 0, 8'h00, 0, "R8");   // left empty
    step(1, 1, 8'h66, 0, "R6");   // head is incoming word
    step(1, 1, 8'h77, 0, "R7");   // full: push dropped
    step(1, 1, 8'h88, 1, "R7");   // full: only pop taken, head 0x66
    step(1, 0, 8'h00, 0, "R7");   // 0x88 was not stored
    step(1, 1, 8'h99, 0, "R9");
    step(1, 0, 8'h00, 1, "R9");   // yields 0x99

    // mixed streams through both copies
    for (int i = 0; i < 60; i++) begin
      step(0, (i % 3) != 0, 8'(i * 7 + 1), (i % 2) == 1, "R9");
      step(1, (i % 3) != 1, 8'(i * 13 + 5), (i % 4) != 0, "R9");
    end

    @(negedge clk);
    push0 = 0; pop0 = 0; push1 = 0; pop1 = 0;
    finish_run();
  end
endmodule